// File: doc/BRIEF.md
# Write-Through Store Queue with Read Forwarding

This block sits between a write-through cache and the next memory level. Processor stores enter a small circular queue in a single cycle. The queue keeps each store's address and data and sends them to memory one at a time, oldest first, over a valid/ready write port. The processor is held back only when every slot is taken.

On each processor read, all occupied slots are compared with the read address in the same cycle. On a match the youngest buffered data is returned, so a read never picks up stale memory contents. A store to an address already waiting in the queue overwrites that slot's data and does not use a new slot. There is one exception: the oldest slot is the one currently offered to memory, and it is never overwritten. A store to its address takes a fresh slot instead.

Top module: `store_drain_queue`

## Requirements
- R1: After reset `empty` is 1, `full` is 0, `count` is 0 and `mem_valid` is 0.
- R2: A store (`st_valid`=1) to an address not in a non-oldest slot, made while `count` < DEPTH, is accepted with `st_stall`=0 and raises `count` by one on the next cycle (unless a drain happens in the same cycle).
- R3: A store that cannot merge, made while `count` = DEPTH, sees `st_stall`=1 in that cycle. It is not stored and `count` does not change.
- R4: Slots leave in arrival order. `mem_valid` is 1 exactly when the queue is not empty, and `mem_addr`/`mem_data` hold steady while `mem_ready` is 0. A slot is freed in the cycle where `mem_valid` and `mem_ready` are both 1.
- R5: With `rd_en`=1, `rd_hit` is 1 in the same cycle when any occupied slot holds `rd_addr`. `rd_data` then carries the data of the youngest such slot. With no match, `rd_hit` is 0. A store made in the same cycle is not visible to the read.
- R6: A store whose address matches a slot other than the oldest replaces that slot's data. `count` is unchanged, and the merged value is what later drains to memory.
- R7: A store whose address matches only the oldest slot, the one on the memory port, takes a new slot. Both values drain, in order.
- R8: A store that takes a new slot, made in the same cycle as a drain handshake, leaves `count` unchanged.
- R9: A merging store is accepted without stall even when the queue is full.
- R10: `full` is 1 exactly when `count` = DEPTH, and `empty` is 1 exactly when `count` = 0. `count` never exceeds DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Processor store request |
| st_addr | input | AW | Store address |
| st_data | input | DW | Store data |
| st_stall | output | 1 | Store refused this cycle; processor must hold |
| rd_en | input | 1 | Processor read lookup |
| rd_addr | input | AW | Read address |
| rd_hit | output | 1 | Read address found in queue |
| rd_data | output | DW | Forwarded data of youngest matching slot |
| mem_valid | output | 1 | Oldest slot offered to memory |
| mem_addr | output | AW | Address of oldest slot |
| mem_data | output | DW | Data of oldest slot |
| mem_ready | input | 1 | Memory accepts the offered write |
| full | output | 1 | All slots occupied |
| empty | output | 1 | No slot occupied |
| count | output | $clog2(DEPTH+1) | Occupied slots |

## Verification
The first pattern is a burst of distinct stores with memory held back, until the queue is full. This separates a correct stall from silent overwriting or a lost entry. Repeated stores to one address are then sent with the drain port idle and again with it active. These separate merging into a queued slot from wrongly merging into the slot already on the port. Reads are made for queued, duplicated and absent addresses to show that the youngest value is forwarded. A long pseudo-random mix of stores, reads and memory back-pressure follows. A reference queue in the bench predicts every drained write, stall and occupancy value for it.

// File: rtl/store_drain_queue.sv
module store_drain_queue #(
  parameter int DEPTH = 4,
  parameter int AW    = 16,
  parameter int DW    = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         st_valid,
  input  logic [AW-1:0]                st_addr,
  input  logic [DW-1:0]                st_data,
  output logic                         st_stall,
  input  logic                         rd_en,
  input  logic [AW-1:0]                rd_addr,
  output logic                         rd_hit,
  output logic [DW-1:0]                rd_data,
  output logic                         mem_valid,
  output logic [AW-1:0]                mem_addr,
  output logic [DW-1:0]                mem_data,
  input  logic                         mem_ready,
  output logic                         full,
  output logic                         empty,
  output logic [$clog2(DEPTH+1)-1:0]   count
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);

  logic [AW-1:0]    addr_q [DEPTH];
  logic [DW-1:0]    data_q [DEPTH];
  logic [PW-1:0]    head, tail;
  logic [CW-1:0]    cnt;
  logic [DEPTH-1:0] live, mrg_hit, rd_match;
  logic [PW-1:0]    mrg_idx, fwd_idx;
  logic             merge, alloc, deq;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    mrg_idx = '0;
    fwd_idx = head;
    for (int i = 0; i < DEPTH; i++) begin
      live[i]     = ((i >= int'(head)) ? (i - int'(head)) : (i + DEPTH - int'(head))) < int'(cnt);
      mrg_hit[i]  = live[i] && (PW'(i) != head) && (addr_q[i] == st_addr);
      rd_match[i] = live[i] && (addr_q[i] == rd_addr);
      if (mrg_hit[i]) mrg_idx = PW'(i);
      if (rd_match[i] && PW'(i) != head) fwd_idx = PW'(i);
    end
  end

  assign full      = (cnt == CW'(DEPTH));
  assign empty     = (cnt == '0);
  assign count     = cnt;
  assign merge     = st_valid && |mrg_hit;
  assign alloc     = st_valid && !merge && !full;
  assign st_stall  = st_valid && !merge && full;
  assign mem_valid = !empty;
  assign mem_addr  = addr_q[head];
  assign mem_data  = data_q[head];
  assign deq       = mem_valid && mem_ready;
  assign rd_hit    = rd_en && |rd_match;
  assign rd_data   = data_q[fwd_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head <= '0;
      tail <= '0;
      cnt  <= '0;
    end else begin
      if (alloc) tail <= bump(tail);
      if (deq)   head <= bump(head);
      cnt <= cnt + CW'(alloc) - CW'(deq);
    end
  end

  always_ff @(posedge clk) begin
    if (alloc) begin
      addr_q[tail] <= st_addr;
      data_q[tail] <= st_data;
    end
    if (merge) data_q[mrg_idx] <= st_data;
  end
endmodule

// File: rtl/store_drain_queue_chk.sv
module store_drain_queue_chk #(
  parameter int DEPTH = 4,
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int CW    = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          st_valid,
  input logic          st_stall,
  input logic          rd_hit,
  input logic          mem_valid,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_data,
  input logic          mem_ready,
  input logic          full,
  input logic          empty,
  input logic [CW-1:0] count
);
  // R3
  stall_only_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_stall |-> full);

  // R4
  port_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_data)));

  // R4
  drain_frees_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_ready && !st_valid) |=> (count == $past(count) - CW'(1)));

  // R10
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  // R10
  empty_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> !mem_valid);

  // R5
  empty_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> !rd_hit);
endmodule

bind store_drain_queue store_drain_queue_chk #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_stall(st_stall), .rd_hit(rd_hit),
  .mem_valid(mem_valid), .mem_addr(mem_addr), .mem_data(mem_data), .mem_ready(mem_ready),
  .full(full), .empty(empty), .count(count)
);

// File: tb/store_drain_queue_test.sv
module store_drain_queue_test;
  localparam int DEPTH = 4;
  localparam int AW    = 16;
  localparam int DW    = 32;
  localparam int CW    = $clog2(DEPTH+1);

  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic st_valid = 0, rd_en = 0, mem_ready = 0;
  logic [AW-1:0] st_addr = '0, rd_addr = '0;
  logic [DW-1:0] st_data = '0;
  logic st_stall, rd_hit, mem_valid, full, empty;
  logic [DW-1:0] rd_data, mem_data;
  logic [AW-1:0] mem_addr;
  logic [CW-1:0] count;

  store_drain_queue #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) uut (
    .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data),
    .st_stall(st_stall), .rd_en(rd_en), .rd_addr(rd_addr), .rd_hit(rd_hit), .rd_data(rd_data),
    .mem_valid(mem_valid), .mem_addr(mem_addr), .mem_data(mem_data), .mem_ready(mem_ready),
    .full(full), .empty(empty), .count(count)
  );

  typedef struct { logic [AW-1:0] a; logic [DW-1:0] d; } item_t;
  item_t exp_q[$];
  int checks = 0, fails = 0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(input bit sv, input logic [AW-1:0] sa, input logic [DW-1:0] sd,
                      input bit re, input logic [AW-1:0] ra, input bit rdy);
    int n, m, f;
    bit exp_stall;
    @(negedge clk);
    st_valid = sv; st_addr = sa; st_data = sd;
    rd_en = re; rd_addr = ra; mem_ready = rdy;
    n = exp_q.size();
    m = -1; f = -1;
    for (int k = 1; k < n; k++) if (exp_q[k].a == sa) m = k;
    for (int k = 0; k < n; k++) if (exp_q[k].a == ra) f = k;
    exp_stall = sv && (m < 0) && (n == DEPTH);
    #5;
    chk(count == CW'(n), "R8", 32'(count), 32'(n));
    chk(full == (n == DEPTH) && empty == (n == 0), "R10", {30'd0, full, empty}, {30'd0, n == DEPTH, n == 0});
    chk(mem_valid == (n != 0), "R4", 32'(mem_valid), 32'(n != 0));
    if (sv) begin
      if (m >= 0)           chk(st_stall == 1'b0, "R9", 32'(st_stall), 0);
      else if (n == DEPTH)  chk(st_stall == 1'b1, "R3", 32'(st_stall), 1);
      else                  chk(st_stall == 1'b0, "R2", 32'(st_stall), 0);
    end
    if (re) begin
      chk(rd_hit == (f >= 0), "R5", 32'(rd_hit), 32'(f >= 0));
      if (f >= 0) chk(rd_data == exp_q[f].d, "R5", rd_data, exp_q[f].d);
    end
    if (sv && !exp_stall) begin
      if (m >= 0) exp_q[m].d = sd;
      else exp_q.push_back('{a: sa, d: sd});
    end
  endtask

  initial begin
    forever begin
      @(negedge clk);
      #8;
      if (rst_n && mem_valid && mem_ready) begin
        if (exp_q.size() == 0) chk(1'b0, "R4", 32'(mem_addr), 0);
        else begin
          chk(mem_addr == exp_q[0].a && mem_data == exp_q[0].d, "R4", mem_data, exp_q[0].d);
          void'(exp_q.pop_front());
        end
      end
    end
  end

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #5;
    // R1
    chk(empty == 1 && full == 0 && count == 0 && mem_valid == 0, "R1",
        {28'd0, empty, full, mem_valid, |count}, 32'h8);
    // fill with distinct addresses, memory held off (R2)
    for (int i = 0; i < DEPTH; i++) step(1, AW'(16'h100 + i*4), 32'hA000 + i, 0, '0, 0);
    // full: new address stalls (R3)
    step(1, 16'h200, 32'hDEAD, 0, '0, 0);
    step(0, '0, '0, 1, 16'h104, 0);
    chk(full == 1 && count == CW'(DEPTH), "R3", 32'(count), DEPTH);
    // R5 miss
    step(0, '0, '0, 1, 16'h300, 0);
    chk(rd_hit == 0, "R5", 32'(rd_hit), 0);
    // R9 / R6: merge into third slot while full
    step(1, 16'h108, 32'hB00B, 0, '0, 0);
    step(0, '0, '0, 1, 16'h108, 0);
    chk(rd_data == 32'hB00B && count == CW'(DEPTH), "R6", rd_data, 32'hB00B);
    // drain all
    for (int i = 0; i < DEPTH + 1; i++) step(0, '0, '0, 0, '0, 1);
    // R7: store to oldest slot's address takes new slot
    step(1, 16'h400, 32'h1, 0, '0, 0);
    step(1, 16'h400, 32'h2, 0, '0, 0);
    step(0, '0, '0, 1, 16'h400, 0);
    chk(count == 2 && rd_data == 32'h2, "R7", 32'(count), 2);
    // R6: third store merges into second slot
    step(1, 16'h400, 32'h3, 0, '0, 0);
    step(0, '0, '0, 0, '0, 0);
    chk(count == 2, "R6", 32'(count), 2);
    // R8: allocate and drain together
    step(1, 16'h500, 32'h5, 0, '0, 1);
    step(0, '0, '0, 0, '0, 0);
    chk(count == 2, "R8", 32'(count), 2);
    for (int i = 0; i < 4; i++) step(0, '0, '0, 0, '0, 1);
    // mixed pseudo-random traffic
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[0], AW'({lfsr[3:1], 2'b00}), {16'd0, lfsr}, lfsr[4],
           AW'({lfsr[7:5], 2'b00}), lfsr[9] | lfsr[8]);
    end
    for (int i = 0; i < DEPTH + 3; i++) step(0, '0, '0, 0, '0, 1);
    step(0, '0, '0, 0, '0, 0);
    chk(empty == 1 && exp_q.size() == 0, "R4", 32'(exp_q.size()), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule